// File: doc/BRIEF.md
# One-Time-Programmable Register Bank

This block holds a set of protectable one-time-programmable registers. There are sixteen wide 128-bit user registers and one 128-bit register split into two 64-bit halves. One half carries a factory identifier and can never change. The other half is free for user data. The non-volatile cells are modelled as flops. On reset the user cells load the erased value (all ones), and the identifier loads from a parameter.

A program request names a register index, a 16-bit word offset inside that register, and a data word. A program can only clear bits: the stored word becomes the old word AND the new data. Two lock words decide protection. The first lock word covers the two 64-bit halves, and its identifier bit starts out protected. The second lock word has one bit per wide register. The lock words follow the same one-way rule, so protection can never be withdrawn. A program aimed at a protected or nonexistent location changes nothing. One cycle after each program the block reports a status. A separate read port returns any word one cycle after the request.

Top module: `otp_bank`

## Requirements
- R1: After reset, every wide-register word and every user-half word reads 16'hFFFF. The per-register lock word reads 16'hFFFF and the half-register lock word reads 16'hFFFE. prog_done and rd_valid are 0 and prog_status is 0 (none).
- R2: A read request (rd_en) gives rd_valid=1 and the addressed word on rd_data on the cycle after the request. With the default sizes, index 0..15 selects wide register 0..15 at offsets 0..7, index 16 the identifier half, index 17 the user half (offsets 0..3), index 18 the half-register lock word and index 19 the per-register lock word (offset 0 only).
- R3: A successful program leaves the addressed word equal to its previous value AND the supplied data, so bits only ever go from one to zero.
- R4: Every program request gives prog_done=1 on the next cycle. prog_status is then 1 (ok) when the location was written.
- R5: A wide register i whose bit i in the per-register lock word is 0 is protected. A program to it returns status 2 (protected) and leaves its contents unchanged.
- R6: The user half is protected when bit 1 of the half-register lock word is 0. A program to it then returns status 2 and changes nothing.
- R7: The identifier half reads as the identifier parameter, with word offset k giving parameter bits [16k+15:16k]. Bit 0 of the half-register lock word stays 0, so every program to the identifier returns status 2.
- R8: Programming a lock word ANDs the data into it with no protection check. Writing ones never clears a protection. Bits 15..2 of the half-register lock word always read as 1.
- R9: An index above 19, or an offset beyond the size of the target register, gives program status 3 (range) with no state change. A read of such a location returns 16'hFFFF.
- R10: A read and a program that hit the same word in the same cycle return the word as it stood before that program. A read one cycle later sees the programmed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, reloads the modelled cells |
| prog_en | input | 1 | Program request |
| prog_idx | input | 5 | Register index to program |
| prog_off | input | 3 | Word offset within the register |
| prog_data | input | 16 | Data word, ANDed into the stored word |
| rd_en | input | 1 | Read request |
| rd_idx | input | 5 | Register index to read |
| rd_off | input | 3 | Word offset to read |
| rd_data | output | 16 | Read word, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| prog_done | output | 1 | Program finished, one cycle after prog_en |
| prog_status | output | 2 | 0 none, 1 ok, 2 protected, 3 range |

## Verification
A read and a program can hit the same word in the same cycle. The stored word changes on the same edge that captures the read data. The bench issues both requests together on one unprotected word and on one protected word. It expects the read to return the pre-program value and a read on the next cycle to show the ANDed value. This is judged against a word model that the bench keeps in step with the requirements.

// File: rtl/otp_bank_pkg.sv
package otp_bank_pkg;

    localparam int IDX_W  = 5;
    localparam int OFF_W  = 3;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        PST_NONE  = 2'd0,
        PST_OK    = 2'd1,
        PST_PROT  = 2'd2,
        PST_RANGE = 2'd3
    } prog_stat_e;

    typedef enum logic [2:0] {
        TGT_WIDE  = 3'd0,
        TGT_UID   = 3'd1,
        TGT_USER  = 3'd2,
        TGT_LOCKA = 3'd3,
        TGT_LOCKB = 3'd4,
        TGT_NONE  = 3'd5
    } tgt_e;

    typedef struct packed {
        logic       done;
        prog_stat_e stat;
    } prog_rsp_t;

    // one-way cell update: a one may become zero, never the reverse
    function automatic logic [WORD_W-1:0] burn(input logic [WORD_W-1:0] cur,
                                               input logic [WORD_W-1:0] req);
        return cur & req;
    endfunction

endpackage

// File: rtl/otp_bank_decode.sv
module otp_bank_decode
    import otp_bank_pkg::*;
#(
    parameter int NUM_WIDE   = 16,
    parameter int WIDE_WORDS = 8,
    parameter int HALF_WORDS = 4,
    parameter int SEL_W      = 4,
    parameter int WOFF_W     = 3,
    parameter int HOFF_W     = 2
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [OFF_W-1:0]  off,
    output tgt_e              kind,
    output logic [SEL_W-1:0]  sel,
    output logic [WOFF_W-1:0] wword,
    output logic [HOFF_W-1:0] hword
);

    localparam int IDX_UID   = NUM_WIDE;
    localparam int IDX_USER  = NUM_WIDE + 1;
    localparam int IDX_LOCKA = NUM_WIDE + 2;
    localparam int IDX_LOCKB = NUM_WIDE + 3;

    always_comb begin
        kind = TGT_NONE;
        if (int'(idx) < NUM_WIDE) begin
            if (int'(off) < WIDE_WORDS) kind = TGT_WIDE;
        end else if (int'(idx) == IDX_UID) begin
            if (int'(off) < HALF_WORDS) kind = TGT_UID;
        end else if (int'(idx) == IDX_USER) begin
            if (int'(off) < HALF_WORDS) kind = TGT_USER;
        end else if (int'(idx) == IDX_LOCKA) begin
            if (off == '0) kind = TGT_LOCKA;
        end else if (int'(idx) == IDX_LOCKB) begin
            if (off == '0) kind = TGT_LOCKB;
        end
    end

    assign sel   = idx[SEL_W-1:0];
    assign wword = off[WOFF_W-1:0];
    assign hword = off[HOFF_W-1:0];

endmodule

// File: rtl/otp_bank_locks.sv
module otp_bank_locks
    import otp_bank_pkg::*;
#(
    parameter int NUM_WIDE = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we_a,
    input  logic                we_b,
    input  logic [WORD_W-1:0]   wdata,
    output logic [1:0]          lock_a,
    output logic [NUM_WIDE-1:0] lock_b
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_a <= 2'b10;          // identifier half protected from the start
            lock_b <= '1;
        end else begin
            if (we_a) lock_a <= lock_a & wdata[1:0];
            if (we_b) lock_b <= lock_b & wdata[NUM_WIDE-1:0];
        end
    end

    // R8
    lock_one_way_chk: assert property (@(posedge clk) disable iff (rst)
        ((lock_a & ~$past(lock_a)) == '0) && ((lock_b & ~$past(lock_b)) == '0));

    // R7
    uid_lock_held_chk: assert property (@(posedge clk) disable iff (rst)
        !lock_a[0]);

endmodule

// File: rtl/otp_bank_store.sv
module otp_bank_store
    import otp_bank_pkg::*;
#(
    parameter int NUM_WIDE   = 16,
    parameter int WIDE_WORDS = 8,
    parameter int HALF_WORDS = 4,
    parameter int SEL_W      = 4,
    parameter int WOFF_W     = 3,
    parameter int HOFF_W     = 2,
    parameter logic [HALF_WORDS*WORD_W-1:0] UID_VALUE = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we_wide,
    input  logic                we_user,
    input  logic [SEL_W-1:0]    w_sel,
    input  logic [WOFF_W-1:0]   w_wword,
    input  logic [HOFF_W-1:0]   w_hword,
    input  logic [WORD_W-1:0]   wdata,
    input  logic                rd_en,
    input  tgt_e                rd_kind,
    input  logic [SEL_W-1:0]    rd_sel,
    input  logic [WOFF_W-1:0]   rd_wword,
    input  logic [HOFF_W-1:0]   rd_hword,
    input  logic [1:0]          lock_a,
    input  logic [NUM_WIDE-1:0] lock_b,
    output logic [WORD_W-1:0]   rd_data
);

    localparam int PAD_B = WORD_W - NUM_WIDE;

    logic [NUM_WIDE-1:0][WIDE_WORDS-1:0][WORD_W-1:0] wide_q;
    logic [HALF_WORDS-1:0][WORD_W-1:0]               user_q;
    logic [WORD_W-1:0] lock_a_word, lock_b_word, rd_word;

    assign lock_a_word = {{(WORD_W-2){1'b1}}, lock_a};

    generate
        if (PAD_B > 0) begin : g_pad_b
            assign lock_b_word = {{PAD_B{1'b1}}, lock_b};
        end else begin : g_full_b
            assign lock_b_word = lock_b;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            wide_q <= '1;
            user_q <= '1;
        end else begin
            if (we_wide) wide_q[w_sel][w_wword] <= burn(wide_q[w_sel][w_wword], wdata);
            if (we_user) user_q[w_hword] <= burn(user_q[w_hword], wdata);
        end
    end

    always_comb begin
        case (rd_kind)
            TGT_WIDE:  rd_word = wide_q[rd_sel][rd_wword];
            TGT_UID:   rd_word = UID_VALUE[int'(rd_hword)*WORD_W +: WORD_W];
            TGT_USER:  rd_word = user_q[rd_hword];
            TGT_LOCKA: rd_word = lock_a_word;
            TGT_LOCKB: rd_word = lock_b_word;
            default:   rd_word = '1;
        endcase
    end

    // read captures the pre-write array, giving read-before-write ordering
    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '1;
        else if (rd_en) rd_data <= rd_word;
    end

    // R3
    cell_one_way_chk: assert property (@(posedge clk) disable iff (rst)
        ((wide_q & ~$past(wide_q)) == '0) && ((user_q & ~$past(user_q)) == '0));

    // R5
    wide_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we_wide |=> $stable(wide_q));

    // R6
    user_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we_user |=> $stable(user_q));

endmodule

// File: rtl/otp_bank.sv
module otp_bank
    import otp_bank_pkg::*;
#(
    parameter int NUM_WIDE   = 16,
    parameter int WIDE_WORDS = 8,
    parameter int HALF_WORDS = 4,
    parameter logic [HALF_WORDS*WORD_W-1:0] UID_VALUE = 64'hA5C3_1E0F_7D92_4B68
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_en,
    input  logic [IDX_W-1:0]  prog_idx,
    input  logic [OFF_W-1:0]  prog_off,
    input  logic [WORD_W-1:0] prog_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              prog_done,
    output logic [1:0]        prog_status
);

    localparam int SEL_W  = (NUM_WIDE   > 1) ? $clog2(NUM_WIDE)   : 1;
    localparam int WOFF_W = (WIDE_WORDS > 1) ? $clog2(WIDE_WORDS) : 1;
    localparam int HOFF_W = (HALF_WORDS > 1) ? $clog2(HALF_WORDS) : 1;

    tgt_e              p_kind, r_kind;
    logic [SEL_W-1:0]  p_sel, r_sel;
    logic [WOFF_W-1:0] p_wword, r_wword;
    logic [HOFF_W-1:0] p_hword, r_hword;
    logic [1:0]          lock_a;
    logic [NUM_WIDE-1:0] lock_b;
    prog_stat_e p_stat;
    logic       accept;
    prog_rsp_t  rsp_q;

    otp_bank_decode #(
        .NUM_WIDE(NUM_WIDE), .WIDE_WORDS(WIDE_WORDS), .HALF_WORDS(HALF_WORDS),
        .SEL_W(SEL_W), .WOFF_W(WOFF_W), .HOFF_W(HOFF_W)
    ) u_prog_dec (
        .idx(prog_idx), .off(prog_off),
        .kind(p_kind), .sel(p_sel), .wword(p_wword), .hword(p_hword)
    );

    otp_bank_decode #(
        .NUM_WIDE(NUM_WIDE), .WIDE_WORDS(WIDE_WORDS), .HALF_WORDS(HALF_WORDS),
        .SEL_W(SEL_W), .WOFF_W(WOFF_W), .HOFF_W(HOFF_W)
    ) u_rd_dec (
        .idx(rd_idx), .off(rd_off),
        .kind(r_kind), .sel(r_sel), .wword(r_wword), .hword(r_hword)
    );

    always_comb begin
        case (p_kind)
            TGT_WIDE: p_stat = lock_b[p_sel] ? PST_OK : PST_PROT;
            TGT_UID:  p_stat = lock_a[0]     ? PST_OK : PST_PROT;
            TGT_USER: p_stat = lock_a[1]     ? PST_OK : PST_PROT;
            TGT_NONE: p_stat = PST_RANGE;
            default:  p_stat = PST_OK;
        endcase
    end

    assign accept = prog_en && (p_stat == PST_OK);

    otp_bank_locks #(.NUM_WIDE(NUM_WIDE)) u_locks (
        .clk(clk), .rst(rst),
        .we_a(accept && (p_kind == TGT_LOCKA)),
        .we_b(accept && (p_kind == TGT_LOCKB)),
        .wdata(prog_data),
        .lock_a(lock_a), .lock_b(lock_b)
    );

    otp_bank_store #(
        .NUM_WIDE(NUM_WIDE), .WIDE_WORDS(WIDE_WORDS), .HALF_WORDS(HALF_WORDS),
        .SEL_W(SEL_W), .WOFF_W(WOFF_W), .HOFF_W(HOFF_W), .UID_VALUE(UID_VALUE)
    ) u_store (
        .clk(clk), .rst(rst),
        .we_wide(accept && (p_kind == TGT_WIDE)),
        .we_user(accept && (p_kind == TGT_USER)),
        .w_sel(p_sel), .w_wword(p_wword), .w_hword(p_hword), .wdata(prog_data),
        .rd_en(rd_en), .rd_kind(r_kind), .rd_sel(r_sel),
        .rd_wword(r_wword), .rd_hword(r_hword),
        .lock_a(lock_a), .lock_b(lock_b),
        .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q    <= '{done: 1'b0, stat: PST_NONE};
            rd_valid <= 1'b0;
        end else begin
            rsp_q.done <= prog_en;
            if (prog_en) rsp_q.stat <= p_stat;
            rd_valid <= rd_en;
        end
    end

    assign prog_done   = rsp_q.done;
    assign prog_status = rsp_q.stat;

    // R4
    done_follows_chk: assert property (@(posedge clk) disable iff (rst)
        prog_en |=> prog_done);

    // R4
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !prog_en |=> !prog_done);

    // R2
    rd_valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    // R6
    user_prot_chk: assert property (@(posedge clk) disable iff (rst)
        prog_en && (p_kind == TGT_USER) && !lock_a[1] |=> prog_status == PST_PROT);

    // R9
    range_chk: assert property (@(posedge clk) disable iff (rst)
        prog_en && (p_kind == TGT_NONE) |=> prog_status == PST_RANGE);

endmodule

// File: tb/otp_bank_test.sv
`timescale 1ns/1ps
module otp_bank_test;

    localparam logic [63:0] UID = 64'hA5C3_1E0F_7D92_4B68;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_en = 1'b0;
    logic [4:0]  prog_idx = '0;
    logic [2:0]  prog_off = '0;
    logic [15:0] prog_data = '0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_idx = '0;
    logic [2:0]  rd_off = '0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        prog_done;
    logic [1:0]  prog_status;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [15:0] mdl [0:19][0:7];

    always #2 clk = ~clk;

    otp_bank #(.UID_VALUE(UID)) uut (
        .clk(clk), .rst(rst),
        .prog_en(prog_en), .prog_idx(prog_idx), .prog_off(prog_off), .prog_data(prog_data),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_off(rd_off),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .prog_done(prog_done), .prog_status(prog_status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit loc_ok(input int idx, input int off);
        if (idx < 16) return off < 8;
        if (idx == 16 || idx == 17) return off < 4;
        if (idx == 18 || idx == 19) return off == 0;
        return 1'b0;
    endfunction

    function automatic logic [15:0] exp_rd(input int idx, input int off);
        if (!loc_ok(idx, off)) return 16'hFFFF;
        return mdl[idx][off];
    endfunction

    function automatic logic [1:0] exp_st(input int idx, input int off);
        if (!loc_ok(idx, off)) return 2'd3;
        if (idx < 16)  return mdl[19][0][idx] ? 2'd1 : 2'd2;
        if (idx == 16) return mdl[18][0][0] ? 2'd1 : 2'd2;
        if (idx == 17) return mdl[18][0][1] ? 2'd1 : 2'd2;
        return 2'd1;
    endfunction

    task automatic mdl_apply(input int idx, input int off, input logic [15:0] d);
        if (exp_st(idx, off) == 2'd1) begin
            mdl[idx][off] = mdl[idx][off] & d;
            if (idx == 18) mdl[18][0][15:2] = '1;
        end
    endtask

    task automatic do_prog(input int idx, input int off, input logic [15:0] d, input string req);
        logic [1:0] es;
        es = exp_st(idx, off);
        @(negedge clk);
        prog_en = 1'b1; prog_idx = idx[4:0]; prog_off = off[2:0]; prog_data = d;
        @(negedge clk);
        prog_en = 1'b0;
        chk(req, {31'd0, prog_done}, 32'd1, "prog_done");
        chk(req, {30'd0, prog_status}, {30'd0, es}, $sformatf("status idx=%0d off=%0d", idx, off));
        mdl_apply(idx, off, d);
    endtask

    task automatic do_read(input int idx, input int off, input string req);
        logic [15:0] er;
        er = exp_rd(idx, off);
        @(negedge clk);
        rd_en = 1'b1; rd_idx = idx[4:0]; rd_off = off[2:0];
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, {31'd0, rd_valid}, 32'd1, "rd_valid");
        chk(req, {16'd0, rd_data}, {16'd0, er}, $sformatf("data idx=%0d off=%0d", idx, off));
    endtask

    task automatic do_both(input int idx, input int off, input logic [15:0] d, input string req);
        logic [15:0] er;
        logic [1:0]  es;
        er = exp_rd(idx, off);
        es = exp_st(idx, off);
        @(negedge clk);
        prog_en = 1'b1; prog_idx = idx[4:0]; prog_off = off[2:0]; prog_data = d;
        rd_en = 1'b1;   rd_idx = idx[4:0];   rd_off = off[2:0];
        @(negedge clk);
        prog_en = 1'b0; rd_en = 1'b0;
        chk(req, {16'd0, rd_data}, {16'd0, er}, "same-cycle read value");
        chk(req, {30'd0, prog_status}, {30'd0, es}, "same-cycle status");
        mdl_apply(idx, off, d);
        do_read(idx, off, req);
    endtask

    task automatic sweep_reads(input string req);
        for (int i = 0; i < 32; i++)
            for (int o = 0; o < 8; o++)
                do_read(i, o, req);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        for (int i = 0; i < 20; i++)
            for (int o = 0; o < 8; o++)
                mdl[i][o] = 16'hFFFF;
        for (int o = 0; o < 4; o++) mdl[16][o] = UID[o*16 +: 16];
        mdl[18][0] = 16'hFFFE;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset outputs
        chk("R1", {31'd0, prog_done}, 32'd0, "prog_done after reset");
        chk("R1", {31'd0, rd_valid}, 32'd0, "rd_valid after reset");
        chk("R1", {30'd0, prog_status}, 32'd0, "status after reset");
        // R1 R2 R7 R9 erased contents, identifier, lock words, out-of-range reads
        sweep_reads("R1");

        // R3 R4 R7 first pattern over every real location
        for (int i = 0; i < 18; i++)
            for (int o = 0; o < 8; o++)
                if (loc_ok(i, o))
                    do_prog(i, o, 16'hFFFF ^ (16'h0101 << ((i * 3 + o) % 8)), (i == 16) ? "R7" : "R4");
        // R3 second pattern ANDs in further zeros
        for (int i = 0; i < 18; i++)
            for (int o = 0; o < 8; o++)
                if (loc_ok(i, o))
                    do_prog(i, o, ~(16'h0001 << ((i + 5 * o) % 16)), "R3");
        // R3 ones never restore bits
        do_prog(4, 2, 16'hFFFF, "R3");
        sweep_reads("R3");

        // R10 same-cycle read and program on an unprotected word
        do_both(2, 3, 16'h00F0, "R10");
        do_both(17, 1, 16'h0FF0, "R10");

        // R9 range errors
        for (int i = 20; i < 32; i++) do_prog(i, 0, 16'h0000, "R9");
        do_prog(16, 4, 16'h0000, "R9");
        do_prog(17, 7, 16'h0000, "R9");
        do_prog(18, 1, 16'h0000, "R9");
        do_prog(19, 5, 16'h0000, "R9");
        sweep_reads("R9");

        // R5 protect even-numbered wide registers, then try to zero all
        do_prog(19, 0, 16'hAAAA, "R8");
        for (int i = 0; i < 16; i++)
            for (int o = 0; o < 8; o++)
                do_prog(i, o, 16'h0000, "R5");
        // R10 same-cycle on a protected word
        do_both(6, 0, 16'h0000, "R10");
        // R8 ones do not unprotect
        do_prog(19, 0, 16'hFFFF, "R8");
        do_prog(18, 0, 16'hFFFF, "R8");
        do_read(19, 0, "R8");
        do_read(18, 0, "R8");
        // R6 user half protected by lock bit 1
        do_prog(17, 2, 16'h1234, "R6");
        do_prog(18, 0, 16'hFFFD, "R6");
        for (int o = 0; o < 4; o++) do_prog(17, o, 16'h0000, "R6");
        // R7 identifier never changes
        for (int o = 0; o < 4; o++) do_prog(16, o, 16'h0000, "R7");
        sweep_reads("R5");

        finished = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            report();
            $finish;
        end
    end

endmodule